// File: doc/BRIEF.md
# Condition Code Pass Evaluator

This unit decides, within the same cycle, whether an instruction guarded by a 4-bit condition field is allowed to take effect. The field, taken from bits 31 to 28 of the instruction word, is compared against the four arithmetic status flags: negative, zero, carry and overflow. The result is one pass bit. There is no register between input and output.

Equality and sign tests read a single flag. Unsigned magnitude tests combine carry with zero. Signed magnitude tests compare negative with overflow, and two of them also use zero. Code 14 always passes. Code 15 is reserved and never passes. Downstream logic uses the pass bit to gate register writes, base writeback and flag updates.

Top module: `cond_pass_eval`

## Requirements
- R1: Code 0 passes exactly when Z is set. Code 1 passes exactly when Z is clear.
- R2: Code 2 passes exactly when C is set. Code 3 passes exactly when C is clear.
- R3: Code 4 passes exactly when N is set. Code 5 passes exactly when N is clear.
- R4: Code 6 passes exactly when V is set. Code 7 passes exactly when V is clear.
- R5: Code 8 passes when C is set and Z is clear. Code 9 passes when C is clear or Z is set.
- R6: Code 10 passes when N equals V. Code 11 passes when N differs from V.
- R7: Code 12 passes when Z is clear and N equals V. Code 13 passes when Z is set or N differs from V.
- R8: Code 14 passes for every flag combination.
- R9: Code 15 never passes, whatever the flags.
- R10: The output is combinational. A change on either input reaches `pass_o` in the same cycle, with no clock.
- R11: Flags are produced by a subtraction a − b, with C set when no borrow occurs. Under those flags, codes 0, 1 and 8 to 13 match the integer relations ==, !=, unsigned >, unsigned <=, signed >=, signed <, signed > and signed <=, in that code order.

Flag input layout: `flags_i[3]` = N, `flags_i[2]` = Z, `flags_i[1]` = C, `flags_i[0]` = V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_i | input | 4 | Condition field (instruction bits 31..28) |
| flags_i | input | 4 | Status flags {N, Z, C, V} (status register bits 31..28) |
| pass_o | output | 1 | High when the instruction may execute |

## Verification
Two functions meet in a single evaluation of the flags: an unsigned decision built from carry and zero, and a signed decision built from negative and overflow. Both are read from one flag set produced by one subtraction. The bench forces this overlap by running operand pairs through an adder model. The pairs are chosen so that the unsigned and signed orderings disagree, for example a negative operand against a small positive one. Each result is judged against the integer comparison of the original operands, and not against a flag formula. A separate exhaustive sweep over all 256 code and flag combinations checks every encoding directly.

// File: rtl/cond_pass_eval.sv
module cond_pass_eval (
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       pass_o
);

  logic fn, fz, fc, fv;
  logic sgn_eq;
  logic base;

  assign fn = flags_i[3];
  assign fz = flags_i[2];
  assign fc = flags_i[1];
  assign fv = flags_i[0];
  assign sgn_eq = ~(fn ^ fv);

  always_comb begin
    case (cond_i[3:1])
      3'd0:    base = fz;
      3'd1:    base = fc;
      3'd2:    base = fn;
      3'd3:    base = fv;
      3'd4:    base = fc & ~fz;
      3'd5:    base = sgn_eq;
      3'd6:    base = ~fz & sgn_eq;
      default: base = 1'b1;
    endcase
  end

  assign pass_o = cond_i[0] ? ~base : base;

  always_comb begin
    if (cond_i == 4'd0) p_eq_tracks_z_r1: assert (pass_o == flags_i[2]);
    if (cond_i == 4'd3) p_cc_tracks_c_r2: assert (pass_o == !flags_i[1]);
    if (cond_i == 4'd8 && pass_o) p_hi_needs_carry_r5: assert (flags_i[1] && !flags_i[2]);
    if (cond_i == 4'd12 && pass_o) p_gt_needs_nonzero_r7: assert (!flags_i[2]);
    if (cond_i == 4'd14) p_always_passes_r8: assert (pass_o);
    if (cond_i == 4'd15) p_never_passes_r9: assert (!pass_o);
  end

endmodule

// File: tb/sim_cond_pass_eval.sv
module sim_cond_pass_eval;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [3:0] cond_i;
  logic [3:0] flags_i;
  logic pass_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_pass_eval u0 (.cond_i(cond_i), .flags_i(flags_i), .pass_o(pass_o));

  function automatic bit model(input int c, input int f);
    bit n, z, cy, v;
    n = (f / 8) % 2; z = (f / 4) % 2; cy = (f / 2) % 2; v = f % 2;
    case (c)
      0: return z;       1: return !z;
      2: return cy;      3: return !cy;
      4: return n;       5: return !n;
      6: return v;       7: return !v;
      8: return cy && !z;         9: return !cy || z;
      10: return n == v;          11: return n != v;
      12: return !z && (n == v);  13: return z || (n != v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int c);
    case (c)
      0, 1: return "R1";  2, 3: return "R2";
      4, 5: return "R3";  6, 7: return "R4";
      8, 9: return "R5";  10, 11: return "R6";
      12, 13: return "R7"; 14: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cond=%0d flags=%b actual=%b expected=%b", req, cond_i, flags_i, act, exp);
    end
  endtask

  task automatic cmp_case(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] d;
    d = a - b;
    flags_i = {d[31], d == 32'd0, a >= b, (a[31] != b[31]) && (d[31] != a[31])};
    cond_i = 4'd0;  #1 check("R11 eq", pass_o, a == b);
    cond_i = 4'd1;  #1 check("R11 ne", pass_o, a != b);
    cond_i = 4'd8;  #1 check("R11 hi", pass_o, a > b);
    cond_i = 4'd9;  #1 check("R11 ls", pass_o, a <= b);
    cond_i = 4'd10; #1 check("R11 ge", pass_o, $signed(a) >= $signed(b));
    cond_i = 4'd11; #1 check("R11 lt", pass_o, $signed(a) < $signed(b));
    cond_i = 4'd12; #1 check("R11 gt", pass_o, $signed(a) > $signed(b));
    cond_i = 4'd13; #1 check("R11 le", pass_o, $signed(a) <= $signed(b));
  endtask

  initial begin
    logic [31:0] vals [8];
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h0000_0005;
    vals[6] = 32'hFFFF_FFFB; vals[7] = 32'h8000_0001;

    cond_i = 4'd15; flags_i = 4'hF;
    @(negedge clk);
    check("R9 initial", pass_o, 1'b0);

    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        cond_i = c[3:0]; flags_i = f[3:0];
        #1 check(req_of(c), pass_o, model(c, f));
      end

    cond_i = 4'd0; flags_i = 4'b0000;
    #1 check("R10 before", pass_o, 1'b0);
    flags_i = 4'b0100;
    #1 check("R10 same cycle", pass_o, 1'b1);

    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) cmp_case(vals[i], vals[j]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule